// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Static RAM

This block sits between a clocked host and a byte-wide asynchronous static RAM with a 15-bit address. The host presents a request with an address, a direction bit and write data. It holds the request until `req_ready` is high at a clock edge. Reads return a byte on `rsp_rdata` together with a one-cycle `rsp_valid` strobe. Writes complete silently, and the host sees `req_ready` rise again once the write is done.

On the memory side the block drives active-low enable, write strobe and output enable, plus the address. The shared data bus is split into a driven value, a sampled value and a driver enable, and a pad cell joins them at the chip edge. Every timing window of the memory is a parameter in nanoseconds. Each phase length in clock cycles is found at elaboration by rounding up, with a floor of one cycle. Only one access is in flight at a time.

A read holds the memory in its output-driving state long enough to meet the cycle-time, address-access and output-enable-access limits, and samples the bus on the last of those cycles. A recovery phase follows before the controller may drive the bus again. A write pulses the write strobe for the longest of the pulse-width, address-to-end, enable-to-end and data-setup limits, and keeps output enable inactive throughout.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, `mem_dq_oe` and `rsp_valid` are low, and `req_ready` is high.
- R2: `req_ready` is high only when the controller is idle, with all memory controls high and the drivers off. It is low from the edge that accepts a request until that access has finished.
- R3: A read drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1. A write drives `mem_ce_n`=0 and `mem_we_n`=0, and `mem_oe_n` stays 1 for the whole write.
- R4: `rsp_valid` rises RD cycles after the accepting edge, where RD is the largest of ceil(RD_CYCLE_NS/CLK), ceil(ADDR_ACCESS_NS/CLK), ceil(CE_ACCESS_NS/CLK) and ceil(OE_ACCESS_NS/CLK). `rsp_rdata` is the byte the memory holds at that address.
- R5: `rsp_valid` is high for exactly one cycle per read and never after a write.
- R6: `mem_we_n` stays low for at least WE_PULSE_NS. Before `mem_we_n` rises, the enable and the address have been stable for at least the enable-to-end and address-to-end limits, and the write data for at least DATA_SETUP_NS.
- R7: `mem_dq_oe` is high only while `mem_we_n` is low and during the closing phase that follows, which lasts max(1, ceil(WR_CYCLE_NS/CLK) − WP) cycles. It is never high while the memory is driving.
- R8: `mem_dq_oe` rises no sooner than RELEASE_NS after `mem_oe_n` last rose.
- R9: `mem_addr` does not change while `mem_ce_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Memory enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | DATA_W | Data to drive onto the shared bus |
| mem_dq_in | input | DATA_W | Data sampled from the shared bus |
| mem_dq_oe | output | 1 | Bus driver enable |

## Verification
A phase counter that ends too early shows up at the pins within a single access. On a read, `rsp_valid` arrives a cycle sooner and carries the byte the memory model puts out before its access time. On a write, the strobe is measured short when it rises. A wrong state can also leave the drivers on during a read, or turn them on inside the release window; the memory model flags that on the same cycle. An address or data mix-up appears when the byte is read back, at most a few hundred accesses later in the sweep.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_REC,
        ST_WR,
        ST_WR_END
    } ctrl_st_e;

    // nanoseconds to whole cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [DATA_W-1:0] data_d, data_q;
    logic              vld_d, vld_q;

    always_comb begin
        data_d = capture ? bus_in : data_q;
        vld_d  = capture;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            vld_q  <= vld_d;
        end
    end

    assign rdata  = data_q;
    assign rvalid = vld_q;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
    parameter int ADDR_W          = 15,
    parameter int DATA_W          = 8,
    parameter int CLK_PERIOD_NS   = 8,
    parameter int RD_CYCLE_NS     = 70,
    parameter int ADDR_ACCESS_NS  = 70,
    parameter int CE_ACCESS_NS    = 70,
    parameter int OE_ACCESS_NS    = 35,
    parameter int WR_CYCLE_NS     = 70,
    parameter int WE_PULSE_NS     = 55,
    parameter int ADDR_TO_WEND_NS = 65,
    parameter int CE_TO_WEND_NS   = 65,
    parameter int DATA_SETUP_NS   = 30,
    parameter int RELEASE_NS      = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    import sram_ctrl_pkg::*;

    localparam int unsigned CK = CLK_PERIOD_NS;
    localparam int unsigned RD_CYC = umax(umax(ns_to_cyc(RD_CYCLE_NS, CK), ns_to_cyc(ADDR_ACCESS_NS, CK)),
                                          umax(ns_to_cyc(CE_ACCESS_NS, CK), ns_to_cyc(OE_ACCESS_NS, CK)));
    localparam int unsigned WP_CYC = umax(umax(ns_to_cyc(WE_PULSE_NS, CK), ns_to_cyc(ADDR_TO_WEND_NS, CK)),
                                          umax(ns_to_cyc(CE_TO_WEND_NS, CK), ns_to_cyc(DATA_SETUP_NS, CK)));
    localparam int unsigned WC_CYC = ns_to_cyc(WR_CYCLE_NS, CK);
    localparam int unsigned WE_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int unsigned HZ_CYC = ns_to_cyc(RELEASE_NS, CK);
    localparam int unsigned MAX_CYC = umax(umax(RD_CYC, WP_CYC), umax(WE_CYC, HZ_CYC));
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    typedef struct packed {
        ctrl_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [DATA_W-1:0] dout;
    } ctrl_regs_t;

    ctrl_regs_t       r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic             cap;

    sram_cycle_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap),
        .bus_in  (mem_dq_in),
        .rdata   (rsp_rdata),
        .rvalid  (rsp_valid)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap      = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr = req_addr;
                    r_d.ce_n = 1'b0;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        r_d.we_n  = 1'b0;
                        r_d.dq_oe = 1'b1;
                        r_d.dout  = req_wdata;
                        tmr_val   = CNT_W'(WP_CYC);
                        r_d.st    = ST_WR;
                    end else begin
                        r_d.oe_n = 1'b0;
                        tmr_val  = CNT_W'(RD_CYC);
                        r_d.st   = ST_RD;
                    end
                end
            end
            ST_RD: begin
                if (tmr_last) begin
                    cap      = 1'b1;
                    r_d.ce_n = 1'b1;
                    r_d.oe_n = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HZ_CYC);
                    r_d.st   = ST_RD_REC;
                end
            end
            ST_RD_REC: begin
                if (tmr_last) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_WR: begin
                if (tmr_last) begin
                    r_d.we_n = 1'b1;
                    r_d.ce_n = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WE_CYC);
                    r_d.st   = ST_WR_END;
                end
            end
            ST_WR_END: begin
                if (tmr_last) begin
                    r_d.dq_oe = 1'b0;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.ce_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.dq_oe <= 1'b0;
            r_q.dout  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign mem_addr   = r_q.addr;
    assign mem_ce_n   = r_q.ce_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_dq_out = r_q.dout;
    assign mem_dq_oe  = r_q.dq_oe;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int WP_CYC = 9,
    parameter int HZ_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    localparam int WL_W = $clog2(WP_CYC + 2);
    localparam int HZ_W = $clog2(HZ_CYC + 2);

    logic [WL_W-1:0] we_lo_q;
    logic [HZ_W-1:0] since_oe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_lo_q    <= '0;
            since_oe_q <= HZ_W'(HZ_CYC);
        end else begin
            if (mem_we_n) we_lo_q <= '0;
            else if (we_lo_q < WL_W'(WP_CYC)) we_lo_q <= we_lo_q + 1'b1;
            if (!mem_oe_n) since_oe_q <= '0;
            else if (since_oe_q < HZ_W'(HZ_CYC)) since_oe_q <= since_oe_q + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R2
    AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n)); // R3
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R5
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_q >= WL_W'(WP_CYC))); // R6
    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R7
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (since_oe_q >= HZ_W'(HZ_CYC))); // R8
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R9
endmodule

bind sram_async_ctrl sram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .WP_CYC (WP_CYC),
    .HZ_CYC (HZ_CYC)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
    localparam int CLK = 8;
    localparam int AW  = 8;
    localparam int DW  = 8;
    localparam int NA  = 1 << AW;

    function automatic int cdiv(input int n, input int d);
        int c;
        c = (n + d - 1) / d;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = '0;

    always #4 clk = ~clk;

    sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(CLK)) i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    int rd_e, wp_e, we_e;
    logic [DW-1:0] sb [NA];
    logic [DW-1:0] mem [NA];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // behavioural memory: timing checks at the pins, bus ownership
    int ce_lo = 0, we_lo = 0, oe_lo = 0, a_st = 0, d_st = 0, hold = 0, rel = 1000;
    logic p_we_n = 1'b1, p_ce_n = 1'b1, p_dq_oe = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dout = '0;
    bit wr_oe_bad = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit drv, ok_rd;
            if (mem_we_n && !p_we_n) begin
                chk(we_lo * CLK >= 55, "R6 write pulse ns", we_lo * CLK, 55);
                chk(ce_lo * CLK >= 65, "R6 enable before write end ns", ce_lo * CLK, 65);
                chk(a_st * CLK >= 65, "R6 address before write end ns", a_st * CLK, 65);
                chk(d_st * CLK >= 30, "R6 data setup ns", d_st * CLK, 30);
                chk(!wr_oe_bad, "R3 output enable low during write", int'(wr_oe_bad), 0);
                chk(mem_dq_oe, "R7 drivers held after write end", int'(mem_dq_oe), 1);
                mem[p_addr] = p_dout;
                wr_oe_bad = 1'b0;
            end
            if (!mem_dq_oe && p_dq_oe)
                chk(hold == we_e, "R7 closing phase length", hold, we_e);
            hold = (mem_dq_oe && mem_we_n) ? hold + 1 : 0;
            if (!mem_we_n && !mem_oe_n) wr_oe_bad = 1'b1;
            ce_lo = mem_ce_n ? 0 : ce_lo + 1;
            we_lo = mem_we_n ? 0 : we_lo + 1;
            oe_lo = mem_oe_n ? 0 : oe_lo + 1;
            if (!mem_ce_n && !p_ce_n)
                chk(mem_addr == p_addr, "R9 address moved under enable", int'(mem_addr), int'(p_addr));
            a_st = mem_ce_n ? 0 : ((p_ce_n || mem_addr != p_addr) ? 1 : a_st + 1);
            d_st = !mem_dq_oe ? 0 : ((!p_dq_oe || mem_dq_out != p_dout) ? 1 : d_st + 1);
            drv = !mem_ce_n && !mem_oe_n && mem_we_n;
            if (drv) rel = 0;
            else if (rel < 1000) rel = rel + 1;
            if (mem_dq_oe) chk(!drv, "R7 bus contention", int'(drv), 0);
            if (mem_dq_oe && !p_dq_oe)
                chk((rel - 1) * CLK >= 25, "R8 turnaround ns", (rel - 1) * CLK, 25);
            ok_rd = (ce_lo * CLK >= 70) && (a_st * CLK >= 70) && (oe_lo * CLK >= 35) && (ce_lo * CLK >= 70);
            if (drv) mem_dq_in = ok_rd ? mem[mem_addr] : ~mem[mem_addr];
            else mem_dq_in = 8'h5A;
            p_we_n = mem_we_n; p_ce_n = mem_ce_n; p_dq_oe = mem_dq_oe;
            p_addr = mem_addr; p_dout = mem_dq_out;
        end
    end

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 ready low while writing", int'(req_ready), 0);
        sb[a] = d;
        while (!req_ready) begin
            chk(!rsp_valid, "R5 strobe during write", int'(rsp_valid), 0);
            @(negedge clk);
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int lat;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 ready low while reading", int'(req_ready), 0);
        chk(!mem_ce_n && !mem_oe_n && mem_we_n, "R3 read control levels",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
        lat = 0;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == rd_e, "R4 read latency cycles", lat, rd_e);
        chk(rsp_rdata == sb[a], "R4 read data", int'(rsp_rdata), int'(sb[a]));
        @(negedge clk);
        chk(!rsp_valid, "R5 strobe one cycle", int'(rsp_valid), 0);
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R2 watchdog expired", 0, 1);
        summary();
    end

    initial begin
        logic [15:0] lfsr;
        rd_e = imax(imax(cdiv(70, CLK), cdiv(70, CLK)), imax(cdiv(70, CLK), cdiv(35, CLK)));
        wp_e = imax(imax(cdiv(55, CLK), cdiv(65, CLK)), imax(cdiv(65, CLK), cdiv(30, CLK)));
        we_e = (cdiv(70, CLK) > wp_e) ? cdiv(70, CLK) - wp_e : 1;
        for (int i = 0; i < NA; i++) begin
            sb[i] = '0;
            mem[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mem_ce_n, "R1 enable after reset", int'(mem_ce_n), 1);
        chk(mem_we_n, "R1 write strobe after reset", int'(mem_we_n), 1);
        chk(mem_oe_n, "R1 output enable after reset", int'(mem_oe_n), 1);
        chk(!mem_dq_oe, "R1 drivers after reset", int'(mem_dq_oe), 0);
        chk(!rsp_valid, "R1 strobe after reset", int'(rsp_valid), 0);
        chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
        // sweep: write every address, read every address back
        for (int a = 0; a < NA; a++) do_write(AW'(a), DW'(a * 37 + 11));
        for (int a = 0; a < NA; a++) do_read(AW'(a));
        // inverted pattern, read-after-write at the same address
        for (int a = 0; a < NA; a += 5) begin
            do_write(AW'(a), ~DW'(a * 37 + 11));
            do_read(AW'(a));
        end
        // pseudo-random mix of directions and addresses
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) begin
                do_write(lfsr[AW:1], lfsr[15:8]);
                if (lfsr[1]) do_read(lfsr[AW:1]);
            end else begin
                do_read(lfsr[AW:1]);
            end
        end
        repeat (3) @(negedge clk);
        chk(req_ready && mem_ce_n && !mem_dq_oe, "R2 idle after traffic", int'(req_ready), 1);
        summary();
    end
endmodule